// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This block walks one device transaction at a time through a fixed translation order. A request carries a device identifier, an optional process identifier with its valid flag, and an I/O virtual address. The sequencer first fetches the device context. If the process identifier is valid, it then fetches the process context. Next it maps the I/O virtual address to a guest physical address through the first stage. It then tests whether that guest physical address lies in a virtual interrupt file. If it does not, the second stage maps it to a supervisor physical address.

Each step is a request/acknowledge exchange with an external helper, and the helpers hold the table walks and context formats. The two stages can never be switched off as a whole. A stage is skipped only when its mode is Bare, and a skipped stage passes the address through unchanged. A fault on any helper ends the transaction and returns a code that names the failing step.

Top module: `iommu_xlate_seq`

## Requirements
- R1: After a request is accepted, the first helper request is always the device-context lookup, carrying the accepted device identifier.
- R2: The process-context lookup is requested, with the accepted process identifier, only when the request's process-valid flag was set.
- R3: The first-stage mode comes from the process context when the process identifier is valid, and from the device context otherwise. In Bare mode the guest physical address equals the input address and no first-stage request is made. Otherwise `s1_addr` carries the input address and the guest physical address is `s1_gpa`.
- R4: The interrupt-file test is made only when the device context enables it. It uses the mask and pattern from that context and matches when `((gpa >> 12) & ~mask) == (pattern & ~mask)`.
- R5: On a match, the response has `rsp_msi` = 1, `rsp_addr` = guest physical address, and `rsp_intf` = the guest page-number bits at the set mask positions, packed from bit 0 upward in ascending order. No second-stage request is made.
- R6: Without a match, Bare second-stage mode returns the guest physical address with no second-stage request. Otherwise `s2_addr` carries the guest physical address and `rsp_addr` = `s2_spa`.
- R7: A helper acknowledge with its fault bit set ends the transaction at once, and no later helper is requested. The fault bit wins over any other field in that acknowledge. The response then has `rsp_fault` = 1, `rsp_msi` = 0, `rsp_addr` = 0 and `rsp_intf` = 0. `rsp_fcode` is 1 for device context, 2 for process context, 3 for first stage and 4 for second stage.
- R8: Only one transaction is in flight at a time. `req_ready` stays low from acceptance until the response handshake completes. The response fields hold steady while `rsp_valid` is high and `rsp_ready` is low.
- R9: After reset, `req_ready` = 1 and all helper requests and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Sequencer idle, takes a transaction |
| req_dev_id | input | DIDW | Device identifier |
| req_pid_valid | input | 1 | Process identifier present |
| req_pid | input | PIDW | Process identifier |
| req_iova | input | AW | I/O virtual address |
| dc_req | output | 1 | Device-context lookup request |
| dc_id | output | DIDW | Device identifier to look up |
| dc_ack | input | 1 | Device-context lookup done |
| dc_fault | input | 1 | Device-context lookup failed |
| dc_s1_bare | input | 1 | First stage Bare when no process identifier |
| dc_s2_bare | input | 1 | Second stage Bare |
| dc_msi_en | input | 1 | Interrupt-file test enabled |
| dc_msi_mask | input | AW-12 | Interrupt-file page mask |
| dc_msi_pattern | input | AW-12 | Interrupt-file page pattern |
| pc_req | output | 1 | Process-context lookup request |
| pc_id | output | PIDW | Process identifier to look up |
| pc_ack | input | 1 | Process-context lookup done |
| pc_fault | input | 1 | Process-context lookup failed |
| pc_s1_bare | input | 1 | First stage Bare for this process |
| s1_req | output | 1 | First-stage translate request |
| s1_addr | output | AW | Address for first stage |
| s1_ack | input | 1 | First stage done |
| s1_fault | input | 1 | First stage failed |
| s1_gpa | input | AW | Guest physical address result |
| s2_req | output | 1 | Second-stage translate request |
| s2_addr | output | AW | Guest physical address for second stage |
| s2_ack | input | 1 | Second stage done |
| s2_fault | input | 1 | Second stage failed |
| s2_spa | input | AW | Supervisor physical address result |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | AW | Final address |
| rsp_msi | output | 1 | Interrupt-file redirect |
| rsp_intf | output | AW-12 | Interrupt file number |
| rsp_fault | output | 1 | Transaction faulted |
| rsp_fcode | output | 3 | Failing step code |

## Verification
Two things can land on the same cycle. One is the response handshake completing while the next transaction is already waiting. The other is a helper acknowledge that carries a fault together with mode or interrupt-file fields that would change the path. For the first case, the bench holds `req_valid` high while stalling `rsp_ready`. It checks that `req_ready` stays low, that no device lookup starts, and that the response is stable. It then checks that the waiting transaction is taken right after the handshake. For the second case, the table vectors raise a fault on acknowledges that also enable the interrupt-file test. The bench checks that only the fault code returns and that no later helper was requested.

// File: rtl/iommu_xlate_seq.sv
module iommu_xlate_seq #(
  parameter int AW   = 56,
  parameter int DIDW = 24,
  parameter int PIDW = 20,
  localparam int MW  = AW - 12,
  localparam int KW  = $clog2(MW) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DIDW-1:0] req_dev_id,
  input  logic            req_pid_valid,
  input  logic [PIDW-1:0] req_pid,
  input  logic [AW-1:0]   req_iova,
  output logic            dc_req,
  output logic [DIDW-1:0] dc_id,
  input  logic            dc_ack,
  input  logic            dc_fault,
  input  logic            dc_s1_bare,
  input  logic            dc_s2_bare,
  input  logic            dc_msi_en,
  input  logic [MW-1:0]   dc_msi_mask,
  input  logic [MW-1:0]   dc_msi_pattern,
  output logic            pc_req,
  output logic [PIDW-1:0] pc_id,
  input  logic            pc_ack,
  input  logic            pc_fault,
  input  logic            pc_s1_bare,
  output logic            s1_req,
  output logic [AW-1:0]   s1_addr,
  input  logic            s1_ack,
  input  logic            s1_fault,
  input  logic [AW-1:0]   s1_gpa,
  output logic            s2_req,
  output logic [AW-1:0]   s2_addr,
  input  logic            s2_ack,
  input  logic            s2_fault,
  input  logic [AW-1:0]   s2_spa,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [AW-1:0]   rsp_addr,
  output logic            rsp_msi,
  output logic [MW-1:0]   rsp_intf,
  output logic            rsp_fault,
  output logic [2:0]      rsp_fcode
);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_PROC, S_ST1, S_CHK, S_ST2, S_RSP
  } step_t;

  step_t           st;
  logic [DIDW-1:0] r_dev;
  logic            r_pidv;
  logic [PIDW-1:0] r_pid;
  logic [AW-1:0]   r_iova, r_gpa, r_addr;
  logic            r_s2b, r_msien, r_msi, r_fault;
  logic [MW-1:0]   r_mask, r_pat, r_intf;
  logic [2:0]      r_code;

  assign req_ready = (st == S_IDLE);
  assign dc_req    = (st == S_DEV);
  assign pc_req    = (st == S_PROC);
  assign s1_req    = (st == S_ST1);
  assign s2_req    = (st == S_ST2);
  assign rsp_valid = (st == S_RSP);
  assign dc_id     = r_dev;
  assign pc_id     = r_pid;
  assign s1_addr   = r_iova;
  assign s2_addr   = r_gpa;
  assign rsp_addr  = r_addr;
  assign rsp_msi   = r_msi;
  assign rsp_intf  = r_intf;
  assign rsp_fault = r_fault;
  assign rsp_fcode = r_code;

  logic [MW-1:0] gpn, file_no;
  logic          hit;

  assign gpn = r_gpa[AW-1:12];
  assign hit = r_msien && (((gpn ^ r_pat) & ~r_mask) == '0);

  always_comb begin
    logic [KW-1:0] k;
    file_no = '0;
    k = '0;
    for (int i = 0; i < MW; i++) begin
      if (r_mask[i]) begin
        file_no[k] = gpn[i];
        k = k + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_dev   <= '0;
      r_pidv  <= 1'b0;
      r_pid   <= '0;
      r_iova  <= '0;
      r_gpa   <= '0;
      r_addr  <= '0;
      r_s2b   <= 1'b0;
      r_msien <= 1'b0;
      r_mask  <= '0;
      r_pat   <= '0;
      r_msi   <= 1'b0;
      r_intf  <= '0;
      r_fault <= 1'b0;
      r_code  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_dev   <= req_dev_id;
          r_pidv  <= req_pid_valid;
          r_pid   <= req_pid;
          r_iova  <= req_iova;
          r_addr  <= '0;
          r_msi   <= 1'b0;
          r_intf  <= '0;
          r_fault <= 1'b0;
          r_code  <= '0;
          st      <= S_DEV;
        end
        S_DEV: if (dc_ack) begin
          if (dc_fault) begin
            r_fault <= 1'b1;
            r_code  <= 3'd1;
            st      <= S_RSP;
          end else begin
            r_s2b   <= dc_s2_bare;
            r_msien <= dc_msi_en;
            r_mask  <= dc_msi_mask;
            r_pat   <= dc_msi_pattern;
            if (r_pidv) st <= S_PROC;
            else if (dc_s1_bare) begin
              r_gpa <= r_iova;
              st    <= S_CHK;
            end else st <= S_ST1;
          end
        end
        S_PROC: if (pc_ack) begin
          if (pc_fault) begin
            r_fault <= 1'b1;
            r_code  <= 3'd2;
            st      <= S_RSP;
          end else if (pc_s1_bare) begin
            r_gpa <= r_iova;
            st    <= S_CHK;
          end else st <= S_ST1;
        end
        S_ST1: if (s1_ack) begin
          if (s1_fault) begin
            r_fault <= 1'b1;
            r_code  <= 3'd3;
            st      <= S_RSP;
          end else begin
            r_gpa <= s1_gpa;
            st    <= S_CHK;
          end
        end
        S_CHK: begin
          r_addr <= r_gpa;
          if (hit) begin
            r_msi  <= 1'b1;
            r_intf <= file_no;
            st     <= S_RSP;
          end else if (r_s2b) st <= S_RSP;
          else st <= S_ST2;
        end
        S_ST2: if (s2_ack) begin
          if (s2_fault) begin
            r_fault <= 1'b1;
            r_code  <= 3'd4;
            r_addr  <= '0;
          end else r_addr <= s2_spa;
          st <= S_RSP;
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_dev_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> dc_req && dc_id == $past(req_dev_id));

  a_r2_proc_needs_pid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_req) |-> $past(dc_req && dc_ack && !dc_fault) && r_pidv);

  a_r4_msi_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_msi |-> r_msien && !rsp_fault);

  a_r6_s2_bare_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && !rsp_msi && r_s2b |-> rsp_addr == r_gpa);

  a_r7_dev_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
    dc_req && dc_ack && dc_fault |=> rsp_valid && rsp_fault && rsp_fcode == 3'd1);

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_msi)
                                && $stable(rsp_fault) && $stable(rsp_fcode) && $stable(rsp_intf));

  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_req || pc_req || s1_req || s2_req || rsp_valid) |-> !req_ready);

endmodule

// File: tb/iommu_xlate_seq_test.sv
module iommu_xlate_seq_test;
  localparam int AW = 56, DIDW = 24, PIDW = 20, MW = AW - 12;
  localparam logic [AW-1:0] S1_OFF = 56'h10_0000_0000;
  localparam logic [AW-1:0] S2_OFF = 56'h800_0000_0000;

  typedef struct packed {
    logic pidv, dcs1b, pcs1b, s2b, msien;
    logic [2:0] fstep;
    logic [AW-1:0] iova;
    logic [MW-1:0] mask, pat;
    logic [2:0] ecode;
    logic emsi;
    logic [AW-1:0] eaddr;
    logic [MW-1:0] eintf;
    logic [3:0] eseen;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{'0,'1,'1,'1,'0,3'd0,56'h12345000,44'h0,44'h0,3'd0,'0,56'h12345000,44'h0,4'b0001},
    '{'0,'0,'1,'0,'0,3'd0,56'h1000,44'h0,44'h0,3'd0,'0,56'h81000001000,44'h0,4'b1101},
    '{'1,'0,'1,'0,'0,3'd0,56'h2000,44'h0,44'h0,3'd0,'0,56'h80000002000,44'h0,4'b1011},
    '{'1,'1,'0,'1,'0,3'd0,56'h3000,44'h0,44'h0,3'd0,'0,56'h1000003000,44'h0,4'b0111},
    '{'0,'1,'1,'0,'1,3'd0,56'h28005000,44'h7,44'h28000,3'd0,'1,56'h28005000,44'h5,4'b0001},
    '{'1,'1,'0,'0,'1,3'd0,56'h28003000,44'h7,44'h1028000,3'd0,'1,56'h1028003000,44'h3,4'b0111},
    '{'0,'1,'1,'0,'0,3'd0,56'h28005000,44'h7,44'h28000,3'd0,'0,56'h80028005000,44'h0,4'b1001},
    '{'0,'1,'1,'0,'1,3'd0,56'h28010000,44'h7,44'h28000,3'd0,'0,56'h80028010000,44'h0,4'b1001},
    '{'0,'1,'1,'0,'1,3'd0,56'h28105000,44'h105,44'h28000,3'd0,'1,56'h28105000,44'h7,4'b0001},
    '{'0,'1,'1,'0,'1,3'd0,56'h28004000,44'h105,44'h28000,3'd0,'1,56'h28004000,44'h2,4'b0001},
    '{'0,'1,'1,'0,'1,3'd0,56'h28001000,44'h7,44'h28007,3'd0,'1,56'h28001000,44'h1,4'b0001},
    '{'1,'0,'0,'0,'1,3'd1,56'h5000,44'h0,44'h0,3'd1,'0,56'h0,44'h0,4'b0001},
    '{'1,'0,'0,'0,'0,3'd2,56'h5000,44'h0,44'h0,3'd2,'0,56'h0,44'h0,4'b0011},
    '{'0,'0,'1,'0,'0,3'd3,56'h5000,44'h0,44'h0,3'd3,'0,56'h0,44'h0,4'b0101},
    '{'0,'0,'1,'0,'0,3'd4,56'h5000,44'h0,44'h0,3'd4,'0,56'h0,44'h0,4'b1101},
    '{'0,'1,'1,'0,'1,3'd4,56'h28005000,44'h7,44'h28000,3'd0,'1,56'h28005000,44'h5,4'b0001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_pid_valid = 1'b0, rsp_ready = 1'b0;
  logic [DIDW-1:0] req_dev_id = '0;
  logic [PIDW-1:0] req_pid = '0;
  logic [AW-1:0] req_iova = '0;
  logic req_ready, dc_req, pc_req, s1_req, s2_req, rsp_valid, rsp_msi, rsp_fault;
  logic [DIDW-1:0] dc_id;
  logic [PIDW-1:0] pc_id;
  logic [AW-1:0] s1_addr, s2_addr, rsp_addr;
  logic [MW-1:0] rsp_intf;
  logic [2:0] rsp_fcode;
  logic dc_ack = 0, dc_fault = 0, pc_ack = 0, pc_fault = 0, s1_ack = 0, s1_fault = 0, s2_ack = 0, s2_fault = 0;
  logic [AW-1:0] s1_gpa = '0, s2_spa = '0;

  vec_t cur = '0;
  int lat = 0, wc = 0;
  logic [3:0] seen = '0;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  iommu_xlate_seq #(.AW(AW), .DIDW(DIDW), .PIDW(PIDW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev_id(req_dev_id), .req_pid_valid(req_pid_valid), .req_pid(req_pid), .req_iova(req_iova),
    .dc_req(dc_req), .dc_id(dc_id), .dc_ack(dc_ack), .dc_fault(dc_fault),
    .dc_s1_bare(cur.dcs1b), .dc_s2_bare(cur.s2b), .dc_msi_en(cur.msien),
    .dc_msi_mask(cur.mask), .dc_msi_pattern(cur.pat),
    .pc_req(pc_req), .pc_id(pc_id), .pc_ack(pc_ack), .pc_fault(pc_fault), .pc_s1_bare(cur.pcs1b),
    .s1_req(s1_req), .s1_addr(s1_addr), .s1_ack(s1_ack), .s1_fault(s1_fault), .s1_gpa(s1_gpa),
    .s2_req(s2_req), .s2_addr(s2_addr), .s2_ack(s2_ack), .s2_fault(s2_fault), .s2_spa(s2_spa),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_msi(rsp_msi),
    .rsp_intf(rsp_intf), .rsp_fault(rsp_fault), .rsp_fcode(rsp_fcode));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d expected done", cycles);
      summary();
    end
  end

  // helper stubs, driven between clock edges
  always @(negedge clk) begin
    if (dc_ack) dc_ack = 0;
    else if (dc_req) begin
      seen[0] = 1'b1;
      if (wc >= lat) begin
        chk(dc_id == req_dev_id, "R1 dc_id", 64'(dc_id), 64'(req_dev_id));
        dc_ack = 1; dc_fault = (cur.fstep == 3'd1); wc = 0;
      end else wc++;
    end
    if (pc_ack) pc_ack = 0;
    else if (pc_req) begin
      seen[1] = 1'b1;
      if (wc >= lat) begin
        chk(pc_id == req_pid, "R2 pc_id", 64'(pc_id), 64'(req_pid));
        pc_ack = 1; pc_fault = (cur.fstep == 3'd2); wc = 0;
      end else wc++;
    end
    if (s1_ack) s1_ack = 0;
    else if (s1_req) begin
      seen[2] = 1'b1;
      if (wc >= lat) begin
        chk(s1_addr == cur.iova, "R3 s1_addr", 64'(s1_addr), 64'(cur.iova));
        s1_ack = 1; s1_fault = (cur.fstep == 3'd3); s1_gpa = s1_addr + S1_OFF; wc = 0;
      end else wc++;
    end
    if (s2_ack) s2_ack = 0;
    else if (s2_req) begin
      seen[3] = 1'b1;
      if (wc >= lat) begin
        s2_ack = 1; s2_fault = (cur.fstep == 3'd4); s2_spa = s2_addr + S2_OFF; wc = 0;
      end else wc++;
    end
  end

  task automatic launch(input int idx);
    cur = TBL[idx];
    seen = '0;
    req_dev_id = DIDW'(idx * 17 + 3);
    req_pid = PIDW'(idx * 5 + 1);
    req_pid_valid = TBL[idx].pidv;
    req_iova = TBL[idx].iova;
    req_valid = 1'b1;
  endtask

  task automatic judge(input int idx);
    vec_t v = TBL[idx];
    chk(rsp_fault == (v.ecode != 0), "R7 rsp_fault", 64'(rsp_fault), 64'(v.ecode != 0));
    chk(rsp_fcode == v.ecode, "R7 rsp_fcode", 64'(rsp_fcode), 64'(v.ecode));
    chk(rsp_msi == v.emsi, "R4 R5 rsp_msi", 64'(rsp_msi), 64'(v.emsi));
    chk(rsp_addr == v.eaddr, "R3 R6 rsp_addr", 64'(rsp_addr), 64'(v.eaddr));
    chk(rsp_intf == v.eintf, "R5 rsp_intf", 64'(rsp_intf), 64'(v.eintf));
    chk(seen == v.eseen, "R2 R3 R5 R6 R7 helpers requested", 64'(seen), 64'(v.eseen));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9 idle after reset",
        64'({req_ready, rsp_valid}), 64'b10);
    chk({dc_req, pc_req, s1_req, s2_req} == 4'b0, "R9 no helper request",
        64'({dc_req, pc_req, s1_req, s2_req}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      launch(i);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 busy after accept", 64'(req_ready), 64'd0);
      while (!rsp_valid) @(negedge clk);
      judge(i);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end

    // response stall with the next transaction already waiting
    lat = 0;
    launch(6);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_addr == TBL[6].eaddr, "R8 response held", 64'(rsp_addr), 64'(TBL[6].eaddr));
      chk(!req_ready && !dc_req, "R8 waiting request not taken", 64'({req_ready, dc_req}), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready == 1'b1 && !dc_req, "R8 idle after handshake", 64'(req_ready), 64'd1);
    launch(4);
    @(negedge clk);
    req_valid = 1'b0;
    chk(dc_req == 1'b1, "R1 waiting request taken", 64'(dc_req), 64'd1);
    while (!rsp_valid) @(negedge clk);
    judge(4);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // back-to-back device-context faults without idle gaps between them
    for (int k = 0; k < 2; k++) begin
      launch(11);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      judge(11);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end

    repeat (2) @(negedge clk);
    summary();
  end
endmodule